// File: doc/BRIEF.md
# I2C Master Status Flag Unit

This block keeps the sticky status flags of an I2C bus master. The master's bit and byte engine drives single-cycle event pulses into it: start condition sent, slave address sent, data byte finished, and stop condition sent. The engine also drives one strobe for each sampled bit. From these pulses the block sets the flags and compares every transmitted bit with the level read back on SDA. It also tracks whether the master still owns the bus. That ownership ends after a programmable bus-free interval that follows a stop, or at once when a transmit mismatch is seen.

Software reads the flags through one 16-bit status word. Each byte of that word has its own byte enable, so the low and high bytes can be reached separately. A flag is cleared by writing 1 to its position. The block also drives an interrupt line, gated by a per-flag mask. In clock-stretch mode it drives an SDA output-disable signal back to the engine, and keeps it asserted until the byte in progress has ended.

Top module: `i2cm_status_unit`

## Requirements
- R1: After reset, rd_data is 0x0000, irq is 0 and sda_block is 0.
- R2: A cycle with evt_stop high sets bit 10 (stop-sent) of rd_data from the next cycle.
- R3: A cycle with evt_byte high sets bit 9 (data-done) from the next cycle.
- R4: A cycle with evt_addr high sets bit 8 (address-done) from the next cycle.
- R5: evt_start sets bit 7 (bus-owned). After evt_stop, bit 7 stays set for N cycles and clears after the Nth, where N = free_time, and a free_time of 0 counts as 1. A new evt_start during that interval cancels the countdown.
- R6: A mismatch sets bit 2 (transmit error) from the next cycle and clears bit 7. A mismatch is a cycle with bit_strobe and tx_active high and tx_bit different from sda_sample.
- R7: A write with wr_en high clears each flag (bits 10, 9, 8, 7, 2) whose wr_data bit is 1, but only when the byte enable for that byte is set. wr_be[0] covers bits 7..0 and wr_be[1] covers bits 15..8. Writing 0, or writing with the byte's enable low, leaves the flag unchanged.
- R8: When a set event and a write-1-to-clear hit the same flag in the same cycle, the flag ends up set.
- R9: While master_en is 0, all flags are cleared from the next cycle, events have no effect on them, and sda_block is cleared.
- R10: Bits 15..11 and 6..3 of rd_data always read 0, even after a write of all ones.
- R11: With stretch_en = 1, a mismatch raises sda_block from the next cycle. sda_block stays high until the cycle after the next evt_byte. With stretch_en = 0, a mismatch never raises sda_block.
- R12: irq is the OR of the masked flags. int_mask[0] gates stop, [1] gates data-done, [2] gates address-done and [3] gates error. Bus-owned never raises irq. With the default REG_IRQ = 0, irq follows the flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Master enable; 0 holds every flag clear |
| stretch_en | input | 1 | Clock-stretch mode; enables SDA suppression on mismatch |
| free_time | input | TW_W | Bus-free interval in system clocks |
| int_mask | input | 4 | Interrupt enables: stop, data, address, error |
| evt_start | input | 1 | Start condition sent pulse |
| evt_addr | input | 1 | Start plus 7-bit address sent pulse |
| evt_byte | input | 1 | Data byte transmitted/received pulse |
| evt_stop | input | 1 | Stop condition sent pulse |
| bit_strobe | input | 1 | SDA sample point for one bit |
| tx_active | input | 1 | The master drives the current bit |
| tx_bit | input | 1 | Bit value the master is sending |
| sda_sample | input | 1 | Level read back on SDA |
| wr_en | input | 1 | Status write strobe |
| wr_be | input | 2 | Byte enables (0: low byte, 1: high byte) |
| wr_data | input | 16 | Write data, 1 clears the flag |
| rd_data | output | 16 | Status word |
| irq | output | 1 | Masked interrupt |
| sda_block | output | 1 | SDA output disable toward the engine |

## Verification
Some rules are checked by the assertions on every cycle. Each event sets its flag one cycle later. A disabled master reads zero. The reserved bits read zero. A set wins over a clear in the same cycle. sda_block rises only after a mismatch seen in stretch mode. irq agrees with the masked flags. Other behaviour is shown only by the bench's scenarios: the exact length of the bus-free window, including the zero case and cancellation by a new start, the byte-enable gating of clears, and the release of sda_block at the next byte end.

// File: rtl/i2cm_stat_pkg.sv
package i2cm_stat_pkg;
   localparam int unsigned WORD_W  = 16;
   localparam int unsigned NBYTES  = WORD_W / 8;
   localparam int unsigned NFLAGS  = 5;
   localparam int unsigned NIRQSRC = 4;

   // flag indices inside the internal flag vector
   typedef enum int unsigned {
      F_ERR   = 0,
      F_OWN   = 1,
      F_ADDR  = 2,
      F_DATA  = 3,
      F_STOP  = 4
   } flag_idx_e;

   // bit position of each flag in the status word
   function automatic int unsigned flag_pos(input int unsigned idx);
      case (idx)
         0: flag_pos = 2;
         1: flag_pos = 7;
         2: flag_pos = 8;
         3: flag_pos = 9;
         default: flag_pos = 10;
      endcase
   endfunction

   localparam logic [WORD_W-1:0] LIVE_MASK = 16'h0784;
endpackage

// File: rtl/i2cm_sticky_flag.sv
module i2cm_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (!enable) q <= 1'b0;
      else if (set_i)   q <= 1'b1;
      else if (clr_i)   q <= 1'b0;
   end
endmodule

// File: rtl/i2cm_busfree_timer.sv
module i2cm_busfree_timer #(
   parameter int unsigned TW_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            load_i,
   input  logic            cancel_i,
   input  logic [TW_W-1:0] free_time,
   output logic            expire_o
);
   localparam logic [TW_W-1:0] ONE = TW_W'(1);

   logic [TW_W-1:0] cnt;
   logic            run;
   logic [TW_W-1:0] load_val;

   assign load_val = (free_time == '0) ? ONE : free_time;
   assign expire_o = run && (cnt == ONE) && !load_i && !cancel_i && enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (!enable || cancel_i) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (load_i) begin
         cnt <= load_val;
         run <= 1'b1;
      end else if (run) begin
         if (cnt == ONE) begin
            cnt <= '0;
            run <= 1'b0;
         end else begin
            cnt <= cnt - ONE;
         end
      end
   end
endmodule

// File: rtl/i2cm_tx_compare.sv
module i2cm_tx_compare (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic stretch_en,
   input  logic bit_strobe,
   input  logic tx_active,
   input  logic tx_bit,
   input  logic sda_sample,
   input  logic byte_done,
   output logic mismatch_o,
   output logic sda_block_o
);
   assign mismatch_o = enable && bit_strobe && tx_active && (tx_bit != sda_sample);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         sda_block_o <= 1'b0;
      else if (!enable)                   sda_block_o <= 1'b0;
      else if (mismatch_o && stretch_en)  sda_block_o <= 1'b1;
      else if (byte_done)                 sda_block_o <= 1'b0;
   end
endmodule

// File: rtl/i2cm_status_unit.sv
module i2cm_status_unit
   import i2cm_stat_pkg::*;
#(
   parameter int unsigned TW_W    = 16,
   parameter bit          REG_IRQ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_en,
   input  logic              stretch_en,
   input  logic [TW_W-1:0]   free_time,
   input  logic [3:0]        int_mask,
   input  logic              evt_start,
   input  logic              evt_addr,
   input  logic              evt_byte,
   input  logic              evt_stop,
   input  logic              bit_strobe,
   input  logic              tx_active,
   input  logic              tx_bit,
   input  logic              sda_sample,
   input  logic              wr_en,
   input  logic [1:0]        wr_be,
   input  logic [15:0]       wr_data,
   output logic [15:0]       rd_data,
   output logic              irq,
   output logic              sda_block
);
   generate
      if (TW_W < 1 || TW_W > 32) begin : g_bad_tw
         $error("TW_W must lie in 1..32");
      end
      if (NBYTES != 2) begin : g_bad_word
         $error("status word must be two bytes");
      end
   endgenerate

   logic [NFLAGS-1:0] flag_q;
   logic [NFLAGS-1:0] hw_set;
   logic [NFLAGS-1:0] clr;
   logic              mismatch;
   logic              expire;

   i2cm_tx_compare u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (master_en),
      .stretch_en (stretch_en),
      .bit_strobe (bit_strobe),
      .tx_active  (tx_active),
      .tx_bit     (tx_bit),
      .sda_sample (sda_sample),
      .byte_done  (evt_byte),
      .mismatch_o (mismatch),
      .sda_block_o(sda_block)
   );

   i2cm_busfree_timer #(.TW_W(TW_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (master_en),
      .load_i   (evt_stop),
      .cancel_i (evt_start),
      .free_time(free_time),
      .expire_o (expire)
   );

   always_comb begin
      hw_set         = '0;
      hw_set[F_ERR]  = mismatch;
      hw_set[F_OWN]  = evt_start;
      hw_set[F_ADDR] = evt_addr;
      hw_set[F_DATA] = evt_byte;
      hw_set[F_STOP] = evt_stop;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NFLAGS; gi++) begin : g_flag
         localparam int unsigned POS = flag_pos(gi);
         logic w1c;
         logic hw_clr;
         assign w1c = wr_en && wr_be[POS/8] && wr_data[POS];
         if (gi == F_OWN) begin : g_own
            assign hw_clr = expire || mismatch;
         end else begin : g_plain
            assign hw_clr = 1'b0;
         end
         assign clr[gi] = w1c || hw_clr;
         i2cm_sticky_flag u_f (
            .clk   (clk),
            .rst_n (rst_n),
            .enable(master_en),
            .set_i (hw_set[gi]),
            .clr_i (clr[gi]),
            .q     (flag_q[gi])
         );
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NFLAGS; i++) rd_data[flag_pos(i)] = flag_q[i];
   end

   logic unused_wr;
   assign unused_wr = ^(wr_data & ~LIVE_MASK);

   logic irq_c;
   assign irq_c = |({flag_q[F_ERR], flag_q[F_ADDR], flag_q[F_DATA], flag_q[F_STOP]} & int_mask);

   generate
      if (REG_IRQ) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_c;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_c;
      end
   endgenerate
endmodule

// File: rtl/i2cm_status_unit_chk.sv
module i2cm_status_unit_chk #(
   parameter bit REG_IRQ = 1'b0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        master_en,
   input logic        stretch_en,
   input logic [3:0]  int_mask,
   input logic        evt_start,
   input logic        evt_addr,
   input logic        evt_byte,
   input logic        evt_stop,
   input logic        bit_strobe,
   input logic        tx_active,
   input logic        tx_bit,
   input logic        sda_sample,
   input logic        wr_en,
   input logic [1:0]  wr_be,
   input logic [15:0] wr_data,
   input logic [15:0] rd_data,
   input logic        irq,
   input logic        sda_block
);
   logic mis;
   assign mis = bit_strobe && tx_active && (tx_bit != sda_sample);

   logic [3:0] masked;
   assign masked = {rd_data[2], rd_data[8], rd_data[9], rd_data[10]} & int_mask;

   // R2
   stop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_stop && master_en) |=> rd_data[10]);
   // R3
   byte_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_byte && master_en) |=> rd_data[9]);
   // R4
   addr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_addr && master_en) |=> rd_data[8]);
   // R6
   mismatch_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mis && master_en && !evt_start) |=> (rd_data[2] && !rd_data[7]));
   // R8
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_start && master_en && wr_en && wr_be[0] && wr_data[7]) |=> rd_data[7]);
   // R9
   disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !master_en |=> (rd_data == 16'h0000 && !sda_block));
   // R10
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[15:11] == 5'd0 && rd_data[6:3] == 4'd0));
   // R11
   block_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_block) |-> $past(mis && stretch_en && master_en));

   generate
      if (REG_IRQ) begin : g_reg
         // R12
         irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq == $past(|masked)));
      end else begin : g_comb
         // R12
         irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq == (|masked));
      end
   endgenerate
endmodule

bind i2cm_status_unit i2cm_status_unit_chk #(.REG_IRQ(REG_IRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .master_en(master_en), .stretch_en(stretch_en),
   .int_mask(int_mask), .evt_start(evt_start), .evt_addr(evt_addr),
   .evt_byte(evt_byte), .evt_stop(evt_stop), .bit_strobe(bit_strobe),
   .tx_active(tx_active), .tx_bit(tx_bit), .sda_sample(sda_sample),
   .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
   .irq(irq), .sda_block(sda_block)
);

// File: tb/tb_i2cm_status_unit.sv
`timescale 1ns/1ps
module tb_i2cm_status_unit;
   localparam int TW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic master_en = 1'b0, stretch_en = 1'b0;
   logic [TW-1:0] free_time = '0;
   logic [3:0] int_mask = 4'hF;
   logic evt_start = 0, evt_addr = 0, evt_byte = 0, evt_stop = 0;
   logic bit_strobe = 0, tx_active = 0, tx_bit = 0, sda_sample = 0;
   logic wr_en = 0;
   logic [1:0] wr_be = 0;
   logic [15:0] wr_data = 0;
   logic [15:0] rd_data;
   logic irq, sda_block;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   i2cm_status_unit #(.TW_W(TW)) dut (
      .clk(clk), .rst_n(rst_n), .master_en(master_en), .stretch_en(stretch_en),
      .free_time(free_time), .int_mask(int_mask), .evt_start(evt_start),
      .evt_addr(evt_addr), .evt_byte(evt_byte), .evt_stop(evt_stop),
      .bit_strobe(bit_strobe), .tx_active(tx_active), .tx_bit(tx_bit),
      .sda_sample(sda_sample), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
      .rd_data(rd_data), .irq(irq), .sda_block(sda_block)
   );

   // {start,addr,byte,stop, mismatch, wr, be[1:0], wdata[15:0], expect[15:0]}
   localparam int NV = 18;
   localparam logic [39:0] VEC [NV] = '{
      {4'b1000, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0080},
      {4'b0100, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0180},
      {4'b0010, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0380},
      {4'b0000, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0380},
      {4'b0000, 1'b0, 1'b1, 2'b11, 16'h0100, 16'h0280},
      {4'b0000, 1'b0, 1'b1, 2'b01, 16'h0200, 16'h0280},
      {4'b0000, 1'b0, 1'b1, 2'b10, 16'h0200, 16'h0080},
      {4'b0001, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0480},
      {4'b0000, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0480},
      {4'b0000, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0480},
      {4'b0000, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0400},
      {4'b0000, 1'b0, 1'b1, 2'b11, 16'hFFFF, 16'h0000},
      {4'b1000, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0080},
      {4'b0000, 1'b1, 1'b0, 2'b00, 16'h0000, 16'h0004},
      {4'b0000, 1'b0, 1'b1, 2'b01, 16'h0004, 16'h0000},
      {4'b1000, 1'b0, 1'b1, 2'b01, 16'h0080, 16'h0080},
      {4'b0010, 1'b0, 1'b1, 2'b10, 16'h0200, 16'h0280},
      {4'b0000, 1'b0, 1'b1, 2'b11, 16'h0680, 16'h0000}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
      end
   endtask

   // drive one cycle of stimulus at a falling edge, release at the next falling edge
   task automatic cyc(input logic [3:0] ev, input logic mis, input logic wr,
                      input logic [1:0] be, input logic [15:0] wd);
      {evt_start, evt_addr, evt_byte, evt_stop} = ev;
      bit_strobe = mis; tx_active = mis; tx_bit = mis; sda_sample = 1'b0;
      wr_en = wr; wr_be = be; wr_data = wd;
      @(negedge clk);
      {evt_start, evt_addr, evt_byte, evt_stop} = '0;
      bit_strobe = 0; tx_active = 0; tx_bit = 0;
      wr_en = 0; wr_be = 0; wr_data = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 rd_data", rd_data, 16'h0000);
      check("R1 irq", {15'd0, irq}, 16'h0000);
      check("R1 sda_block", {15'd0, sda_block}, 16'h0000);
      rst_n = 1'b1;
      master_en = 1'b1;
      free_time = 16'd3;
      @(negedge clk);

      // table walk: R2 R3 R4 R5 R6 R7 R8 R10 R12
      for (int i = 0; i < NV; i++) begin
         logic [15:0] e;
         e = VEC[i][15:0];
         cyc(VEC[i][39:36], VEC[i][35], VEC[i][34], VEC[i][33:32], VEC[i][31:16]);
         check($sformatf("R2/R3/R4/R5/R6/R7/R8/R10 vec%0d", i), rd_data, e);
         check($sformatf("R12 vec%0d irq", i), {15'd0, irq},
               {15'd0, e[10] | e[9] | e[8] | e[2]});
      end

      // R5 zero free_time behaves as one cycle
      free_time = 16'd0;
      cyc(4'b1000, 0, 0, 2'b00, 0);
      cyc(4'b0001, 0, 0, 2'b00, 0);
      check("R5 zero window first", rd_data & 16'h0080, 16'h0080);
      cyc(4'b0000, 0, 0, 2'b00, 0);
      check("R5 zero window cleared", rd_data & 16'h0080, 16'h0000);

      // R5 new start cancels countdown
      free_time = 16'd3;
      cyc(4'b1000, 0, 0, 2'b00, 0);
      cyc(4'b0001, 0, 0, 2'b00, 0);
      cyc(4'b0000, 0, 0, 2'b00, 0);
      cyc(4'b1000, 0, 0, 2'b00, 0);
      for (int k = 0; k < 5; k++) cyc(4'b0000, 0, 0, 2'b00, 0);
      check("R5 start cancels timer", rd_data & 16'h0080, 16'h0080);
      cyc(4'b0000, 0, 1, 2'b11, 16'hFFFF);

      // R12 individual mask bits
      cyc(4'b0010, 0, 0, 2'b00, 0);
      int_mask = 4'b0010; #0.1;
      check("R12 data enabled", {15'd0, irq}, 16'h0001);
      int_mask = 4'b1101; #0.1;
      check("R12 data masked", {15'd0, irq}, 16'h0000);
      cyc(4'b1000, 0, 1, 2'b10, 16'h0200);
      int_mask = 4'b0111; #0.1;
      check("R12 owned never irq", {15'd0, irq}, 16'h0000);
      cyc(4'b0000, 1, 0, 2'b00, 0);
      int_mask = 4'b1000; #0.1;
      check("R12 error enabled", {15'd0, irq}, 16'h0001);
      int_mask = 4'hF;
      check("R11 no block without stretch", {15'd0, sda_block}, 16'h0000);
      cyc(4'b0000, 0, 1, 2'b11, 16'hFFFF);

      // R11 stretch mode suppression
      stretch_en = 1'b1;
      cyc(4'b0000, 1, 0, 2'b00, 0);
      check("R11 block raised", {15'd0, sda_block}, 16'h0001);
      cyc(4'b0000, 0, 0, 2'b00, 0);
      check("R11 block held", {15'd0, sda_block}, 16'h0001);
      cyc(4'b0010, 0, 0, 2'b00, 0);
      check("R11 block released at byte end", {15'd0, sda_block}, 16'h0000);
      cyc(4'b0000, 1, 0, 2'b00, 0);
      check("R11 block raised again", {15'd0, sda_block}, 16'h0001);

      // R9 master disable clears and blocks events
      cyc(4'b1110, 0, 0, 2'b00, 0);
      master_en = 1'b0;
      cyc(4'b0000, 0, 0, 2'b00, 0);
      check("R9 cleared on disable", rd_data, 16'h0000);
      check("R9 block cleared", {15'd0, sda_block}, 16'h0000);
      cyc(4'b1111, 1, 0, 2'b00, 0);
      check("R9 events ignored", rd_data, 16'h0000);
      check("R9 irq low", {15'd0, irq}, 16'h0000);
      master_en = 1'b1;
      stretch_en = 1'b0;

      // R10 reserved bits after all-ones write with flags set
      cyc(4'b1111, 0, 0, 2'b00, 0);
      cyc(4'b0000, 0, 1, 2'b00, 16'hFFFF);
      check("R10 reserved zero", rd_data & ~16'h0784, 16'h0000);
      check("R7 write without enables ignored", rd_data, 16'h0780);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule